// File: doc/BRIEF.md
# Receive Halt and Resume Controller

This block sits on the receive side of a one-way serial link, one instance per application stream. The link has no return channel, so a damaged or missing word cannot be sent again. Each word that arrives from the deframer is held in a small verification buffer and numbered with a tag. A word is written into the application FIFO only after an upstream integrity check has released it with a commit. The FIFO write uses `wr_en`, `wr_data` and `wr_eop`.

When the checker reports a link error, the error event carries the tag of the last word known to be good. Every buffered word up to and including that tag is still written out. All later words are discarded, the stream stops, and the sticky `halt` output goes high. While halted, the block ignores all incoming words, commits and further error events. `halt` falls only when the error condition has cleared and the application requests a resume; holding `resume` high all the time is allowed. After a resume, delivery restarts on a word boundary at an unknown point in the sender's stream.

When the optional realignment is chosen at the resume, the block also drops every word up to and including the first word that carries the end-of-packet flag. Each instance has its own `halt`, so streams that share one link reach the halted state at different times. There is no full-flag flow control: only the halt state gates writes.

Top module: `rxhalt_guard`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `halt` and `wr_en` are 0.
- R2: Words are numbered in arrival order from 0, starting at reset and again after every resume. A word's tag is its number modulo 2*DEPTH. A commit with tag T releases every word up to and including T. Released words are written in arrival order, one per cycle, and a word released by a commit sampled at clock edge k is written (`wr_en`=1) in the cycle after edge k+2 when no earlier word is still waiting. `wr_eop` shows the end-of-packet flag stored with the word.
- R3: A word that has not been released by a commit or by an error event is never written.
- R4: An error event with tag T, sampled while running, releases every buffered word up to T and discards all later ones. `halt` rises in the cycle right after the last of those writes, and no write follows.
- R5: While `halt` is 1, `wr_en` stays 0. Incoming words, commits and error events are ignored.
- R6: While halted and `err_active` is 1, `halt` stays 1 whatever `resume` does.
- R7: While halted, if `resume`=1 and `err_active`=0 are sampled at an edge, `halt` is 0 from the next cycle on, and word numbering restarts at 0.
- R8: With `resume` held at 1, `halt` falls in the cycle after `err_active` is sampled at 0.
- R9: If `resync_en` is 1 when the resume is sampled, the released words up to and including the first word with the end-of-packet flag set are not written. Writing resumes with the next word. If `resync_en` is 0 at that point, no words are dropped.
- R10: An error event that arrives after a first one, while the buffer is still being emptied, does not change which words are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word from the deframer is present |
| in_data | input | DW | Word from the deframer |
| in_eop | input | 1 | End-of-packet flag of the arriving word |
| commit_valid | input | 1 | Integrity check releases words |
| commit_tag | input | log2(DEPTH)+1 | Tag of the last released word |
| err_event | input | 1 | Link error detected (pulse) |
| err_tag | input | log2(DEPTH)+1 | Tag of the last good word at the error |
| err_active | input | 1 | Error condition still present |
| resume | input | 1 | Application asks to restart |
| resync_en | input | 1 | Drop words up to the first end-of-packet word after a restart |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | DW | FIFO write word |
| wr_eop | output | 1 | End-of-packet flag of the written word |
| halt | output | 1 | Stream is halted |

## Verification
A commit sampled at an edge produces its write three edges later. The bench drives stimulus on the falling edge and checks `wr_en` and `wr_data` at the third falling edge after the commit, and checks that no write appears at the two falling edges before it. For an error with three words still to write, `halt` is checked low at the falling edge where the last write is visible and high one cycle later. A resume, or `err_active` falling while `resume` is held, is checked by looking for `halt` low at the very next falling edge. All other writes are compared in order against a queue that bench functions fill from the commits, errors and realignment rule. At the end of each phase the bench checks that the queue is empty and that the number of writes is as expected.

// File: rtl/rxhg_pkg.sv
package rxhg_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/rxhg_buf.sv
// Verification buffer: simple dual-port memory with a registered read port.
module rxhg_buf #(
  parameter int WW = 17,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  localparam int NWORDS = 1 << AW;

  logic [WW-1:0] mem [0:NWORDS-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxhg_ctrl.sv
// Pointer and halt state machine.
// wp: next tag to assign. cp: first word not yet released. rp: next word to read.
module rxhg_ctrl
  import rxhg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          commit_valid,
  input  logic [AW:0]   commit_tag,
  input  logic          err_event,
  input  logic [AW:0]   err_tag,
  input  logic          err_active,
  input  logic          resume,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          restart,
  output logic          halt
);
  localparam logic [AW:0] ONE = 1;

  rx_state_t   st;
  logic [AW:0] wp, rp, cp;
  logic        rd_q;
  logic        full;

  // Pointers carry one extra wrap bit, so full and empty can be told apart.
  assign full      = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign mem_we    = (st == ST_RUN) && in_valid && !full;
  assign mem_waddr = wp[AW-1:0];
  assign mem_re    = (st != ST_HALT) && (rp != cp);
  assign mem_raddr = rp[AW-1:0];
  assign restart   = (st == ST_HALT) && resume && !err_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_RUN;
      wp   <= '0;
      rp   <= '0;
      cp   <= '0;
      rd_q <= 1'b0;
      halt <= 1'b0;
    end else begin
      rd_q <= mem_re;
      if (mem_re) rp <= rp + ONE;
      unique case (st)
        ST_RUN: begin
          if (err_event) begin
            // Keep up to the last good word; forget everything after it.
            cp <= err_tag + ONE;
            wp <= err_tag + ONE;
            st <= ST_DRAIN;
          end else begin
            if (mem_we)       wp <= wp + ONE;
            if (commit_valid) cp <= commit_tag + ONE;
          end
        end
        ST_DRAIN: begin
          // Halt once the last kept word has left the read register.
          if (rp == cp && !rd_q) begin
            st   <= ST_HALT;
            halt <= 1'b1;
          end
        end
        ST_HALT: begin
          if (restart) begin
            st   <= ST_RUN;
            halt <= 1'b0;
            wp   <= '0;
            rp   <= '0;
            cp   <= '0;
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/rxhg_resync.sv
// Output stage: registers the FIFO write and drops words after a realigning restart.
module rxhg_resync #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_issue,
  input  logic [DW:0]   rdata,
  input  logic          restart,
  input  logic          resync_en,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          wr_eop
);
  logic rd_vld;
  logic drop_q;
  logic word_eop;

  assign word_eop = rdata[DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      drop_q  <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      wr_eop  <= 1'b0;
    end else begin
      rd_vld <= rd_issue;
      wr_en  <= rd_vld && !drop_q;
      if (rd_vld) begin
        wr_data <= rdata[DW-1:0];
        wr_eop  <= word_eop;
      end
      if (restart)
        drop_q <= resync_en;
      else if (rd_vld && drop_q && word_eop)
        drop_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxhalt_guard.sv
module rxhalt_guard #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [DW-1:0]           in_data,
  input  logic                    in_eop,
  input  logic                    commit_valid,
  input  logic [$clog2(DEPTH):0]  commit_tag,
  input  logic                    err_event,
  input  logic [$clog2(DEPTH):0]  err_tag,
  input  logic                    err_active,
  input  logic                    resume,
  input  logic                    resync_en,
  output logic                    wr_en,
  output logic [DW-1:0]           wr_data,
  output logic                    wr_eop,
  output logic                    halt
);
  localparam int AW = $clog2(DEPTH);
  localparam int WW = DW + 1;

  logic          mem_we, mem_re, restart;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [WW-1:0] mem_rdata;

  rxhg_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .commit_valid (commit_valid),
    .commit_tag   (commit_tag),
    .err_event    (err_event),
    .err_tag      (err_tag),
    .err_active   (err_active),
    .resume       (resume),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_re       (mem_re),
    .mem_raddr    (mem_raddr),
    .restart      (restart),
    .halt         (halt)
  );

  rxhg_buf #(.WW(WW), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata ({in_eop, in_data}),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  rxhg_resync #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_issue  (mem_re),
    .rdata     (mem_rdata),
    .restart   (restart),
    .resync_en (resync_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_eop    (wr_eop)
  );
endmodule

// File: rtl/rxhg_chk.sv
module rxhg_chk (
  input logic clk,
  input logic rst,
  input logic halt,
  input logic wr_en,
  input logic resume,
  input logic err_active
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!halt && !wr_en));
  // R5
  a_r5_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halt |-> !wr_en);
  // R6
  a_r6_hold_while_active: assert property (@(posedge clk) disable iff (rst)
    (halt && err_active) |=> halt);
  // R6
  a_r6_hold_without_resume: assert property (@(posedge clk) disable iff (rst)
    (halt && !resume) |=> halt);
  // R7
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (halt && resume && !err_active) |=> !halt);
  // R7
  a_r7_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(halt) |-> $past(resume && !err_active));
endmodule

bind rxhalt_guard rxhg_chk u_rxhg_chk (
  .clk        (clk),
  .rst        (rst),
  .halt       (halt),
  .wr_en      (wr_en),
  .resume     (resume),
  .err_active (err_active)
);

// File: tb/tb_rxhalt_guard.sv
module tb_rxhalt_guard;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int TW    = $clog2(DEPTH) + 1;
  localparam int WDOG  = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          commit_valid = 1'b0, err_event = 1'b0;
  logic [TW-1:0] commit_tag = '0, err_tag = '0;
  logic          err_active = 1'b0, resume = 1'b0, resync_en = 1'b0;
  logic          wr_en, wr_eop, halt;
  logic [DW-1:0] wr_data;

  rxhalt_guard #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop),
    .commit_valid(commit_valid), .commit_tag(commit_tag), .err_event(err_event),
    .err_tag(err_tag), .err_active(err_active), .resume(resume), .resync_en(resync_en),
    .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop), .halt(halt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, wr_total = 0;
  bit done = 1'b0;
  logic [DW:0] hist [0:2047];
  logic [DW:0] expq [$];
  int next_cnt = 0, commit_cnt = 0;
  bit drop_m = 1'b0, mhalt = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected FIFO contents: words released up to index n, after the realignment filter.
  function automatic void push_upto(input int n);
    for (int i = commit_cnt; i < n; i++) begin
      if (drop_m) begin
        if (hist[i][DW]) drop_m = 1'b0;
      end else begin
        expq.push_back(hist[i]);
      end
    end
    if (n > commit_cnt) commit_cnt = n;
  endfunction

  always @(negedge clk) begin
    if (!rst && wr_en) begin
      logic [DW:0] e;
      wr_total++;
      if (expq.size() == 0)
        chk(1'b0, "R3", "write of an unreleased word", {wr_eop, wr_data}, 0);
      else begin
        e = expq.pop_front();
        chk({wr_eop, wr_data} == e, "R2", "in-order write", {wr_eop, wr_data}, e);
      end
    end
  end

  task automatic step(input bit v, input logic [DW-1:0] d, input bit e,
                      input bit cv, input int cidx, input bit ev, input int eidx,
                      input bit res);
    in_valid = v; in_data = d; in_eop = e;
    commit_valid = cv; commit_tag = TW'(cidx);
    err_event = ev; err_tag = TW'(eidx); resume = res;
    if (!mhalt) begin
      if (v) begin hist[next_cnt] = {e, d}; next_cnt++; end
      if (ev) begin push_upto(eidx + 1); mhalt = 1'b1; end
      else if (cv) push_upto(cidx + 1);
    end else if (res && !err_active) begin
      mhalt = 1'b0; next_cnt = 0; commit_cnt = 0; drop_m = resync_en;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0; commit_valid = 1'b0;
    err_event = 1'b0; resume = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic send(input logic [DW-1:0] d, input bit e);
    step(1, d, e, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int wb, base, b2;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(!halt && !wr_en, "R1", "outputs during reset", {halt, wr_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!halt && !wr_en, "R1", "outputs after reset", {halt, wr_en}, 0);

    // R2 directed latency: the commit is sampled at one edge, the write is seen three edges later.
    send(8'hA5, 1'b1);
    step(0, '0, 0, 1, 0, 0, 0, 0);
    chk(!wr_en, "R2", "no write one edge after commit", wr_en, 0);
    idle(1);
    chk(!wr_en, "R2", "no write two edges after commit", wr_en, 0);
    idle(1);
    chk(wr_en && wr_data == 8'hA5 && wr_eop, "R2", "write three edges after commit",
        {wr_en, wr_eop, wr_data}, {1'b1, 1'b1, 8'hA5});
    idle(2);

    // R2 random: arrivals and commits mixed
    base = wr_total - next_cnt + 0;
    base = wr_total - commit_cnt;
    for (int i = 0; i < 600; i++) begin
      bit v, cv;
      int ci;
      v  = ($urandom % 3 != 0) && (next_cnt - (wr_total - base) < DEPTH - 2);
      cv = (next_cnt > commit_cnt) && ($urandom % 4 == 0);
      ci = cv ? commit_cnt + int'($urandom % (next_cnt - commit_cnt)) : 0;
      step(v, DW'($urandom), bit'($urandom % 5 == 0), cv, ci, 0, 0, 0);
    end
    if (next_cnt > commit_cnt) step(0, '0, 0, 1, next_cnt - 1, 0, 0, 0);
    idle(8);
    chk(expq.size() == 0, "R2", "released words all written", expq.size(), 0);
    chk(wr_total - base == commit_cnt, "R2", "write count", wr_total - base, commit_cnt);

    // R3: unreleased words stay in the buffer
    wb = wr_total;
    send(8'h11, 0); send(8'h22, 0); send(8'h33, 0);
    idle(10);
    chk(wr_total == wb, "R3", "no write without commit", wr_total - wb, 0);

    // R4: error keeps three words, drops two
    send(8'h44, 0); send(8'h55, 0);
    step(0, '0, 0, 0, 0, 1, next_cnt - 3, 0);
    idle(4);
    chk(!halt && wr_en && wr_data == 8'h33, "R4", "last kept word, halt still low",
        {halt, wr_en, wr_data}, {1'b0, 1'b1, 8'h33});
    idle(1);
    chk(halt && !wr_en, "R4", "halt right after last write", {halt, wr_en}, 2'b10);
    chk(wr_total - wb == 3, "R4", "kept word count", wr_total - wb, 3);

    // R5 / R6: halted, error still active; activity and resume are ignored
    err_active = 1'b1;
    wb = wr_total;
    for (int i = 0; i < 6; i++) begin
      step(1, DW'(i), 0, 1, 0, (i == 2), 0, 1);
      chk(halt, "R6", "halt held while error active", halt, 1);
    end
    idle(4);
    chk(wr_total == wb, "R5", "no write while halted", wr_total - wb, 0);

    // R7: resolved error plus resume releases halt, numbering restarts at 0
    err_active = 1'b0;
    step(0, '0, 0, 0, 0, 0, 0, 1);
    chk(!halt, "R7", "halt low after resume", halt, 0);
    wb = wr_total;
    send(8'h3C, 0);
    step(0, '0, 0, 1, 0, 0, 0, 0);
    idle(4);
    chk(wr_total - wb == 1 && expq.size() == 0, "R7", "tag 0 after restart written",
        wr_total - wb, 1);

    // R8: resume held high; halt falls right after err_active clears
    step(0, '0, 0, 0, 0, 1, next_cnt - 1, 0);
    idle(3);
    chk(halt, "R8", "halted after error", halt, 1);
    err_active = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(0, '0, 0, 0, 0, 0, 0, 1);
      chk(halt, "R8", "resume held, error active", halt, 1);
    end
    err_active = 1'b0;
    step(0, '0, 0, 0, 0, 0, 0, 1);
    chk(!halt, "R8", "halt low after error clears", halt, 0);
    idle(2);

    // R10: second error while the buffer is emptying has no effect
    wb = wr_total;
    send(8'h61, 0); send(8'h62, 0); send(8'h63, 0); send(8'h64, 0);
    step(0, '0, 0, 0, 0, 1, 1, 0);
    step(0, '0, 0, 0, 0, 1, 3, 0);
    idle(8);
    chk(halt && wr_total - wb == 2, "R10", "only first error counts",
        wr_total - wb, 2);

    // R9: realigning restart drops words up to the first end-of-packet word
    resync_en = 1'b1;
    step(0, '0, 0, 0, 0, 0, 0, 1);
    resync_en = 1'b0;
    chk(!halt, "R9", "restart with realignment", halt, 0);
    wb = wr_total;
    send(8'h70, 0); send(8'h71, 1); send(8'h72, 0); send(8'h73, 1); send(8'h74, 0);
    step(0, '0, 0, 1, 4, 0, 0, 0);
    idle(8);
    chk(wr_total - wb == 3, "R9", "words after first eop written", wr_total - wb, 3);
    chk(expq.size() == 0, "R9", "expected words delivered", expq.size(), 0);

    // R9: restart without realignment keeps the first word
    step(0, '0, 0, 0, 0, 1, next_cnt - 1, 0);
    idle(3);
    step(0, '0, 0, 0, 0, 0, 0, 1);
    b2 = wr_total;
    send(8'h80, 0);
    step(0, '0, 0, 1, 0, 0, 0, 0);
    idle(5);
    chk(wr_total - b2 == 1, "R9", "no drop when realignment off", wr_total - b2, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule